// File: doc/BRIEF.md
# Framed Timeslot Bit Inserter

This block places the bits of a serial data link into chosen bit positions of an outgoing TDM frame. The line framer supplies, for every bit period, the position of that bit: the frame parity, the timeslot index and the bit number inside the timeslot. The block also receives the frame data that would otherwise be sent. Several inserters share the link, each with its own configuration. An inserter is armed by a master enable, selects even frames, odd frames or both, one timeslot, and an 8-bit mask of bit positions inside that timeslot.

When a bit period matches an armed inserter, the block replaces the frame bit with the bit that the inserter's serializer presents. In the same cycle it pulses that inserter's bit-request strobe, so that the serializer moves on to its next bit. All other bits pass through unchanged. A configuration written at any time is copied into an active set at the first bit of the next frame. Bits within a frame therefore always follow one consistent configuration.

Top module: `ts_bit_inserter`

## Requirements
- R1: After reset, and until the first frame boundary has been seen, no inserter is active: `dout` equals `din` and `bit_req` is all zero, whatever the configuration inputs hold.
- R2: An inserter whose active master enable is 0 never asserts its strobe and never changes `dout`.
- R3: With `frm_odd`=0 (even frame) an inserter acts only if its even enable is 1. With `frm_odd`=1 (odd frame) it acts only if its odd enable is 1. Setting both enables selects every frame.
- R4: An inserter acts only in bit periods where `ts_idx` equals its 5-bit timeslot field. Every value from 0 to 31 can be selected.
- R5: Within the selected timeslot, the bit with `bit_pos`=k is replaced exactly when mask bit k is 1. Bits are sent with `bit_pos` 7 first and 0 last.
- R6: For every replaced bit, exactly one strobe bit of `bit_req` is 1, in the same cycle, and `dout` equals that inserter's `link_bit`. No strobe is raised in a cycle where `bit_en` is 0, and `dout` equals `din` in every cycle with no strobe.
- R7: When several inserters match the same bit, the one with the lowest index wins. Only its strobe is raised and only its bit is sent.
- R8: A frame boundary is a cycle with `frm_start`=1 and `bit_en`=1. The configuration inputs in that cycle become active for that bit and for the rest of the frame. Changes at any other time have no effect until the next boundary.
- R9: Each inserter follows its own enable, parity, timeslot and mask fields, independently of the settings of the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_en | input | 1 | A frame bit period is present this cycle |
| frm_start | input | 1 | First bit of a frame (used with bit_en) |
| frm_odd | input | 1 | Parity of the current frame number, 1 = odd |
| ts_idx | input | 5 | Timeslot index of the current bit |
| bit_pos | input | 3 | Bit number within the timeslot, 7 sent first |
| din | input | 1 | Pass-through frame bit |
| cfg_enable | input | NINS | Master enable per inserter |
| cfg_even | input | NINS | Even-frame enable per inserter |
| cfg_odd | input | NINS | Odd-frame enable per inserter |
| cfg_ts | input | NINS*5 | Timeslot field per inserter, inserter i at [5i+4:5i] |
| cfg_mask | input | NINS*8 | Bit mask per inserter, inserter i at [8i+7:8i] |
| link_bit | input | NINS | Current bit presented by each serializer |
| dout | output | 1 | Merged frame bit |
| bit_req | output | NINS | Per-inserter strobe: the presented bit was consumed |

## Verification
Directed frames each isolate one gate of the match. Parity runs over an even frame and then an odd frame, separating the two enables. Timeslot runs at 0 and 31 expose index decoding at the range edges. Sparse and alternating masks show whether the right bit number maps to the right mask bit. Overlapping configurations on one timeslot check priority. A configuration that changes in mid-frame separates boundary loading from immediate use. Random frames mix all fields, random data, random serializer bits and idle gaps between bit periods. This shows whether strobes line up one-for-one with replaced bits under every combination.

// File: rtl/tsi_pkg.sv
// Package: shared widths and the per-inserter configuration record.
// Assumes a frame of up to 2**TS_W timeslots of SLOT_BITS bits each.
package tsi_pkg;
    localparam int TS_W      = 5;
    localparam int SLOT_BITS = 8;
    localparam int BIT_W     = $clog2(SLOT_BITS);

    typedef struct packed {
        logic                 en;
        logic                 even;
        logic                 odd;
        logic [TS_W-1:0]      ts;
        logic [SLOT_BITS-1:0] mask;
    } ins_cfg_t;
endpackage

// File: rtl/tsi_cfg_shadow.sv
// Holds the active configuration of one inserter.
// Loads the written configuration at a frame boundary. In the boundary
// cycle itself the incoming value is forwarded, so the first bit of the
// frame already uses it. Assumes load is asserted only on a frame's first bit.
module tsi_cfg_shadow
    import tsi_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  ins_cfg_t cfg_in,
    output ins_cfg_t cfg_act
);
    ins_cfg_t shadow_q;

    // Capture the written configuration at each frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shadow_q <= '0;
        else if (load)
            shadow_q <= cfg_in;
    end

    // Forward the new value during the boundary cycle.
    always_comb cfg_act = load ? cfg_in : shadow_q;

    a_r8_hold_midframe: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(shadow_q));

    a_r8_load_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (shadow_q == $past(cfg_in)));
endmodule

// File: rtl/tsi_slot_match.sv
// Decides whether one inserter claims the current bit period.
// Assumes ts_idx and bit_pos describe the bit present when bit_en is high.
module tsi_slot_match
    import tsi_pkg::*;
(
    input  ins_cfg_t         cfg,
    input  logic             bit_en,
    input  logic             frm_odd,
    input  logic [TS_W-1:0]  ts_idx,
    input  logic [BIT_W-1:0] bit_pos,
    output logic             hit
);
    logic parity_ok;
    logic slot_ok;

    // Check that the frame parity is one the inserter selected.
    always_comb parity_ok = frm_odd ? cfg.odd : cfg.even;

    // Check the timeslot and the mask bit for this position.
    always_comb slot_ok = (ts_idx == cfg.ts) && cfg.mask[bit_pos];

    // Combine with the master enable and bit presence.
    always_comb hit = bit_en && cfg.en && parity_ok && slot_ok;
endmodule

// File: rtl/tsi_prio_merge.sv
// Resolves competing claims with fixed priority (lowest index wins).
// Steers the winner's link bit onto the output and raises its strobe.
// With no claim the frame bit passes through.
module tsi_prio_merge #(
    parameter int NINS = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NINS-1:0] hits,
    input  logic [NINS-1:0] link_bit,
    input  logic            din,
    output logic            dout,
    output logic [NINS-1:0] req
);
    logic taken;
    logic sel_bit;

    // Walk inserters from index 0 upward and grant the first claim.
    always_comb begin
        req     = '0;
        taken   = 1'b0;
        sel_bit = 1'b0;
        for (int i = 0; i < NINS; i++) begin
            if (hits[i] && !taken) begin
                req[i]  = 1'b1;
                taken   = 1'b1;
                sel_bit = link_bit[i];
            end
        end
    end

    // Select the inserted bit or the frame bit.
    always_comb dout = taken ? sel_bit : din;

    a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req));

    a_r6_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0) |-> (dout == din));

    for (genvar g = 0; g < NINS; g++) begin : g_chk
        a_r6_data_from_winner: assert property (@(posedge clk) disable iff (!rst_n)
            req[g] |-> (dout == link_bit[g]));
        a_r7_grant_needs_claim: assert property (@(posedge clk) disable iff (!rst_n)
            req[g] |-> hits[g]);
        if (g > 0) begin : g_lower
            a_r7_lower_wins: assert property (@(posedge clk) disable iff (!rst_n)
                req[g] |-> (hits[g-1:0] == '0));
        end
    end
endmodule

// File: rtl/ts_bit_inserter.sv
// Top level: merges up to NINS data-link bit streams into a TDM frame.
// Each inserter has a boundary-loaded configuration and a slot matcher.
// A priority merge picks the winner per bit. Assumes the framer counters
// are valid whenever bit_en is high and that frm_start marks bit 7 of
// timeslot 0.
module ts_bit_inserter
    import tsi_pkg::*;
#(
    parameter int NINS = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bit_en,
    input  logic                      frm_start,
    input  logic                      frm_odd,
    input  logic [TS_W-1:0]           ts_idx,
    input  logic [BIT_W-1:0]          bit_pos,
    input  logic                      din,
    input  logic [NINS-1:0]           cfg_enable,
    input  logic [NINS-1:0]           cfg_even,
    input  logic [NINS-1:0]           cfg_odd,
    input  logic [NINS*TS_W-1:0]      cfg_ts,
    input  logic [NINS*SLOT_BITS-1:0] cfg_mask,
    input  logic [NINS-1:0]           link_bit,
    output logic                      dout,
    output logic [NINS-1:0]           bit_req
);
    logic            boundary;
    logic [NINS-1:0] hits;

    // Recognise a frame boundary.
    always_comb boundary = bit_en && frm_start;

    for (genvar g = 0; g < NINS; g++) begin : g_ins
        ins_cfg_t cfg_wr;
        ins_cfg_t cfg_act;

        // Gather this inserter's fields from the flat configuration buses.
        always_comb begin
            cfg_wr.en   = cfg_enable[g];
            cfg_wr.even = cfg_even[g];
            cfg_wr.odd  = cfg_odd[g];
            cfg_wr.ts   = cfg_ts[g*TS_W +: TS_W];
            cfg_wr.mask = cfg_mask[g*SLOT_BITS +: SLOT_BITS];
        end

        tsi_cfg_shadow i_shadow (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (boundary),
            .cfg_in  (cfg_wr),
            .cfg_act (cfg_act)
        );

        tsi_slot_match i_match (
            .cfg     (cfg_act),
            .bit_en  (bit_en),
            .frm_odd (frm_odd),
            .ts_idx  (ts_idx),
            .bit_pos (bit_pos),
            .hit     (hits[g])
        );
    end

    tsi_prio_merge #(.NINS(NINS)) i_merge (
        .clk      (clk),
        .rst_n    (rst_n),
        .hits     (hits),
        .link_bit (link_bit),
        .din      (din),
        .dout     (dout),
        .req      (bit_req)
    );

    a_r6_strobe_in_bit_period: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_req != '0) |-> bit_en);
endmodule

// File: tb/test_ts_bit_inserter.sv
`timescale 1ns/1ps
module test_ts_bit_inserter;
    localparam int NINS = 3;
    localparam int NTS  = 32;

    logic clk = 1'b0;
    logic rst_n;
    logic bit_en, frm_start, frm_odd, din;
    logic [4:0] ts_idx;
    logic [2:0] bit_pos;
    logic [NINS-1:0] cfg_enable, cfg_even, cfg_odd, link_bit;
    logic [NINS*5-1:0] cfg_ts;
    logic [NINS*8-1:0] cfg_mask;
    logic dout;
    logic [NINS-1:0] bit_req;

    int checks = 0;
    int fails  = 0;
    int frame_no = 0;
    bit done = 0;

    // model of the active configuration
    logic       m_en [NINS];
    logic       m_ev [NINS];
    logic       m_od [NINS];
    logic [4:0] m_ts [NINS];
    logic [7:0] m_mk [NINS];

    // pending configuration applied in mid-frame
    logic [NINS-1:0] p_enable, p_even, p_odd;
    logic [NINS*5-1:0] p_ts;
    logic [NINS*8-1:0] p_mask;

    always #2 clk = ~clk;

    ts_bit_inserter #(.NINS(NINS)) i_ts_bit_inserter (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frm_start(frm_start),
        .frm_odd(frm_odd), .ts_idx(ts_idx), .bit_pos(bit_pos), .din(din),
        .cfg_enable(cfg_enable), .cfg_even(cfg_even), .cfg_odd(cfg_odd),
        .cfg_ts(cfg_ts), .cfg_mask(cfg_mask), .link_bit(link_bit),
        .dout(dout), .bit_req(bit_req)
    );

    task automatic set_ins(input int i, input logic en, input logic ev,
                           input logic od, input logic [4:0] ts, input logic [7:0] mk);
        cfg_enable[i] = en; cfg_even[i] = ev; cfg_odd[i] = od;
        cfg_ts[i*5 +: 5] = ts; cfg_mask[i*8 +: 8] = mk;
    endtask

    task automatic model_reset();
        for (int i = 0; i < NINS; i++) begin
            m_en[i] = 0; m_ev[i] = 0; m_od[i] = 0; m_ts[i] = 0; m_mk[i] = 0;
        end
    endtask

    // One clock: drive at negedge, check 1 ns later, return after posedge.
    task automatic step(input logic ben, input logic st, input int ts,
                        input int bp, input string tag);
        logic load, e_dout, taken, en, ev, od;
        logic [4:0] t;
        logic [7:0] mk;
        logic [NINS-1:0] e_req;
        @(negedge clk);
        bit_en = ben; frm_start = st; ts_idx = 5'(ts); bit_pos = 3'(bp);
        frm_odd = frame_no[0];
        din = 1'($urandom); link_bit = NINS'($urandom);
        #1;
        load = ben && st && rst_n;
        e_req = '0; taken = 0; e_dout = din;
        for (int i = 0; i < NINS; i++) begin
            en = load ? cfg_enable[i] : m_en[i];
            ev = load ? cfg_even[i]   : m_ev[i];
            od = load ? cfg_odd[i]    : m_od[i];
            t  = load ? cfg_ts[i*5 +: 5]  : m_ts[i];
            mk = load ? cfg_mask[i*8 +: 8] : m_mk[i];
            if (load) begin
                m_en[i] = en; m_ev[i] = ev; m_od[i] = od; m_ts[i] = t; m_mk[i] = mk;
            end
            if (!taken && ben && en && (frm_odd ? od : ev) &&
                (ts_idx == t) && mk[bit_pos]) begin
                taken = 1; e_req[i] = 1'b1; e_dout = link_bit[i];
            end
        end
        checks++;
        if (dout !== e_dout || bit_req !== e_req) begin
            fails++;
            $display("FAIL %s: ts=%0d bit=%0d dout=%b exp %b req=%b exp %b",
                     tag, ts, bp, dout, e_dout, bit_req, e_req);
        end
        @(posedge clk);
    endtask

    // One full frame; pending config applied at timeslot chg_ts (-1: never).
    task automatic run_frame(input string tag, input int gap_pct, input int chg_ts);
        for (int ts = 0; ts < NTS; ts++) begin
            if (ts == chg_ts) begin
                cfg_enable = p_enable; cfg_even = p_even; cfg_odd = p_odd;
                cfg_ts = p_ts; cfg_mask = p_mask;
            end
            for (int bp = 7; bp >= 0; bp--) begin
                while (($urandom % 100) < gap_pct) step(0, 0, ts, bp, tag);
                step(1, (ts == 0 && bp == 7), ts, bp, tag);
            end
        end
        frame_no++;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not finish, exp completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234_5678));
        rst_n = 0; bit_en = 0; frm_start = 0; frm_odd = 0; din = 0;
        ts_idx = 0; bit_pos = 0; link_bit = 0;
        cfg_enable = '1; cfg_even = '1; cfg_odd = '1; cfg_ts = '0; cfg_mask = '1;
        model_reset();
        // R1: reset state and before first boundary
        for (int k = 0; k < 4; k++) step(0, 0, 0, 7, "R1");
        rst_n = 1;
        for (int bp = 7; bp >= 0; bp--) step(1, 0, 0, bp, "R1");
        // R2: master enable off
        cfg_enable = '0;
        run_frame("R2", 0, -1);
        // R3: parity selection on even then odd frame
        cfg_enable = '0;
        set_ins(0, 1, 1, 0, 5'd3, 8'hFF);
        set_ins(1, 1, 0, 1, 5'd4, 8'hFF);
        if (frame_no[0]) frame_no++;
        run_frame("R3", 0, -1);
        run_frame("R3", 0, -1);
        // R4: timeslot edges
        set_ins(0, 1, 1, 1, 5'd31, 8'hFF);
        set_ins(1, 1, 1, 1, 5'd0, 8'hFF);
        run_frame("R4", 0, -1);
        // R5: sparse masks
        set_ins(0, 1, 1, 1, 5'd9, 8'h81);
        set_ins(1, 1, 1, 1, 5'd10, 8'h5A);
        set_ins(2, 1, 1, 1, 5'd11, 8'h01);
        run_frame("R5", 0, -1);
        // R7: overlapping claims on one timeslot
        set_ins(0, 1, 1, 1, 5'd7, 8'h0F);
        set_ins(1, 1, 1, 1, 5'd7, 8'h3C);
        set_ins(2, 1, 1, 1, 5'd7, 8'hFF);
        run_frame("R7", 5, -1);
        // R8: change in mid-frame takes effect next frame
        set_ins(0, 1, 1, 1, 5'd20, 8'hF0);
        set_ins(1, 0, 0, 0, 5'd0, 8'h00);
        set_ins(2, 0, 0, 0, 5'd0, 8'h00);
        p_enable = 3'b011; p_even = 3'b011; p_odd = 3'b011;
        p_ts = {5'd0, 5'd25, 5'd2};
        p_mask = {8'h00, 8'hFF, 8'h0F};
        run_frame("R8", 0, 10);
        run_frame("R8", 0, -1);
        // R9: independent settings
        set_ins(0, 1, 1, 0, 5'd1, 8'hAA);
        set_ins(1, 1, 0, 1, 5'd2, 8'h55);
        set_ins(2, 1, 1, 1, 5'd30, 8'hC3);
        run_frame("R9", 5, -1);
        run_frame("R9", 5, -1);
        // R6: random configurations, mid-frame changes and gaps
        for (int f = 0; f < 20; f++) begin
            for (int i = 0; i < NINS; i++)
                set_ins(i, 1'($urandom % 4 != 0), 1'($urandom), 1'($urandom),
                        5'($urandom % 4), 8'($urandom));
            p_enable = NINS'($urandom); p_even = NINS'($urandom); p_odd = NINS'($urandom);
            p_ts = (NINS*5)'($urandom) & {NINS{5'h03}};
            p_mask = (NINS*8)'($urandom);
            run_frame("R6", 10, int'($urandom % 40));
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule